// File: doc/BRIEF.md
# Program/Erase Suspend Controller

This block sits between a flash command decoder and the write engine that runs program and block-erase algorithms. It watches the command stream for a suspend request while the engine is busy. When it sees one, it asks the engine to pause. Once the engine confirms that it has reached a safe pause point, the block reports the suspension through the status byte. It then holds that state until a resume command arrives or reset is applied. On resume it releases the pause and sends the engine a one-cycle resume strobe.

The block also gates the command stream towards the rest of the command logic. While a block erase is running, only read-status and suspend commands get through; the block drops everything else. Suspend and resume codes that the block consumes itself are never forwarded. Every command that is allowed through comes out one clock cycle after it was accepted.

Top module: `susp_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the pause request, the resume strobe and the forward valid are 0. In the status byte, bit 7 equals the inverse of engine busy, and bits 6 and 2 are 0.
- R2: A suspend code (default 0xB0) accepted while the engine is busy raises the pause request on the following cycle. Status bit 7 stays 0 until the engine acknowledges the pause point.
- R3: When the engine acknowledges a pause of a program operation, status bits 2 and 7 become 1 and bit 6 stays 0, in the cycle after the acknowledge.
- R4: When the engine acknowledges a pause of a block erase, status bits 6 and 7 become 1 and bit 2 stays 0, in the cycle after the acknowledge.
- R5: Once suspended, the state and the status bits do not change when the acknowledge drops, when busy changes or when other commands arrive. Only a resume or a reset ends it.
- R6: A resume code (default 0xD0) accepted while suspended clears status bits 2, 6 and 7. It also drops the pause request and pulses the resume strobe high for exactly one cycle, all in the following cycle.
- R7: While a block erase is running and not suspended, only the read-status code (default 0x70) is forwarded. Every other code is dropped.
- R8: A suspend code accepted while the engine is idle has no effect: the pause request stays 0, the status is unchanged and nothing is forwarded.
- R9: If the engine stops being busy before it acknowledges a pending pause, the request is withdrawn on the next cycle and no suspend status bit is set.
- R10: The block forwards every allowed command with its code one cycle after acceptance. While a program runs, any code other than suspend is allowed. While suspended, any code other than suspend and resume is allowed.
- R11: Reset applied while suspended clears the suspension, the pause request and the status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid_i | input | 1 | A decoded command write is present this cycle |
| cmd_code_i | input | CODE_W | Command code of the write |
| eng_busy_i | input | 1 | Write engine has an operation in progress |
| eng_erase_i | input | 1 | The operation in progress is a block erase (0 = program) |
| eng_pause_ack_i | input | 1 | Engine has reached a pause point and halted |
| eng_pause_req_o | output | 1 | Request to the engine to pause / stay paused |
| eng_resume_o | output | 1 | One-cycle strobe telling the engine to continue |
| fwd_valid_o | output | 1 | Forwarded command valid |
| fwd_code_o | output | CODE_W | Forwarded command code |
| status_o | output | 8 | Status bits: 7 ready, 6 erase suspended, 2 program suspended, others 0 |

## Verification
The bench builds the block with its default parameters: 8-bit codes, 0xB0 for suspend, 0xD0 for resume and 0x70 for read status. With these values the bench can drive the exact codes whose collisions matter. 0xD0 is forwarded as an ordinary code outside suspension but consumed inside it. 0xB0 is consumed in every state and never forwarded. Directed tasks reach the pause-acknowledge race and the busy-drop cancel, and they check each status bit position at the ports.

// File: rtl/susp_pkg.sv
// Package: shared state type and status bit positions for the suspend controller.
// Assumes: status byte layout is fixed; bit positions are decoded by the status reader.
package susp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_SUSP = 2'd2
    } susp_state_t;

    localparam int SR_W          = 8;
    localparam int SR_READY_BIT  = 7;
    localparam int SR_ESUSP_BIT  = 6;
    localparam int SR_PSUSP_BIT  = 2;

endpackage

// File: rtl/susp_cmd_gate.sv
// Module: susp_cmd_gate
// Classifies each incoming command against the controller state, picks out
// suspend and resume requests the controller consumes, and forwards every
// other permitted command through one register stage.
// Assumes: at most one command per cycle; the engine operation type is valid
// whenever busy is high.
module susp_cmd_gate
    import susp_pkg::*;
#(
    parameter int                CODE_W      = 8,
    parameter logic [CODE_W-1:0] SUSP_CODE   = 8'hB0,
    parameter logic [CODE_W-1:0] RESUME_CODE = 8'hD0,
    parameter logic [CODE_W-1:0] RDSTAT_CODE = 8'h70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    input  logic [CODE_W-1:0] cmd_code_i,
    input  susp_state_t       state_i,
    input  logic              op_erase_q_i,
    input  logic              eng_busy_i,
    input  logic              eng_erase_i,
    output logic              take_susp_o,
    output logic              take_resume_o,
    output logic              fwd_valid_o,
    output logic [CODE_W-1:0] fwd_code_o
);

    logic is_susp;
    logic is_resume;
    logic is_rdstat;
    logic erase_live;
    logic fwd_ok;

    // Purpose: decode the three codes this block cares about.
    always_comb begin
        is_susp   = cmd_valid_i && (cmd_code_i == SUSP_CODE);
        is_resume = cmd_valid_i && (cmd_code_i == RESUME_CODE);
        is_rdstat = cmd_valid_i && (cmd_code_i == RDSTAT_CODE);
    end

    // Purpose: decide what is consumed, what is forwarded and what is dropped.
    always_comb begin
        take_susp_o   = 1'b0;
        take_resume_o = 1'b0;
        erase_live    = 1'b0;
        fwd_ok        = 1'b0;
        unique case (state_i)
            ST_IDLE: begin
                erase_live  = eng_busy_i && eng_erase_i;
                take_susp_o = is_susp && eng_busy_i;
                if (erase_live) begin
                    fwd_ok = is_rdstat;
                end else begin
                    fwd_ok = cmd_valid_i && !is_susp;
                end
            end
            ST_PEND: begin
                // operation still running until the engine reaches a pause point
                erase_live = op_erase_q_i;
                if (erase_live) begin
                    fwd_ok = is_rdstat;
                end else begin
                    fwd_ok = cmd_valid_i && !is_susp;
                end
            end
            ST_SUSP: begin
                take_resume_o = is_resume;
                fwd_ok        = cmd_valid_i && !is_susp && !is_resume;
            end
            default: begin
                fwd_ok = 1'b0;
            end
        endcase
    end

    // Purpose: register the forwarded command so downstream sees a clean stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_valid_o <= 1'b0;
            fwd_code_o  <= '0;
        end else begin
            fwd_valid_o <= fwd_ok;
            fwd_code_o  <= fwd_ok ? cmd_code_i : '0;
        end
    end

endmodule

// File: rtl/susp_fsm.sv
// Module: susp_fsm
// Three-state suspend sequencer: idle, pause pending, suspended. Latches the
// operation type at the suspend request, raises the pause request, and emits
// enter/leave events plus a one-cycle resume strobe.
// Assumes: the engine raises its pause acknowledge only while busy; an
// operation that finishes before acknowledging cancels the suspend.
module susp_fsm
    import susp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        take_susp_i,
    input  logic        take_resume_i,
    input  logic        eng_busy_i,
    input  logic        eng_erase_i,
    input  logic        eng_pause_ack_i,
    output susp_state_t state_o,
    output logic        op_erase_q_o,
    output logic        ev_enter_o,
    output logic        ev_leave_o,
    output logic        pause_req_o,
    output logic        resume_o
);

    susp_state_t state_q;
    susp_state_t state_d;
    logic        op_erase_q;
    logic        resume_q;

    // Purpose: next-state logic and event pulses.
    always_comb begin
        state_d    = state_q;
        ev_enter_o = 1'b0;
        ev_leave_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (take_susp_i) begin
                    state_d = ST_PEND;
                end
            end
            ST_PEND: begin
                if (!eng_busy_i) begin
                    state_d = ST_IDLE;          // finished before pausing
                end else if (eng_pause_ack_i) begin
                    state_d    = ST_SUSP;
                    ev_enter_o = 1'b1;
                end
            end
            ST_SUSP: begin
                if (take_resume_i) begin
                    state_d    = ST_IDLE;
                    ev_leave_o = 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Purpose: state, latched operation type and resume strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            op_erase_q <= 1'b0;
            resume_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            resume_q <= ev_leave_o;
            if (state_q == ST_IDLE && take_susp_i) begin
                op_erase_q <= eng_erase_i;
            end
        end
    end

    // Purpose: drive outputs from registered state.
    always_comb begin
        state_o      = state_q;
        op_erase_q_o = op_erase_q;
        pause_req_o  = (state_q == ST_PEND) || (state_q == ST_SUSP);
        resume_o     = resume_q;
    end

endmodule

// File: rtl/susp_status.sv
// Module: susp_status
// Holds the program-suspended and erase-suspended flags and assembles the
// status byte with the ready bit.
// Assumes: enter and leave events never coincide; bit positions come from the package.
module susp_status
    import susp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ev_enter_i,
    input  logic            ev_leave_i,
    input  logic            op_erase_q_i,
    input  susp_state_t     state_i,
    input  logic            eng_busy_i,
    output logic [SR_W-1:0] status_o
);

    logic psusp_q;
    logic esusp_q;
    logic ready;

    // Purpose: set the flag matching the paused operation, clear both on resume.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psusp_q <= 1'b0;
            esusp_q <= 1'b0;
        end else if (ev_enter_i) begin
            psusp_q <= !op_erase_q_i;
            esusp_q <= op_erase_q_i;
        end else if (ev_leave_i) begin
            psusp_q <= 1'b0;
            esusp_q <= 1'b0;
        end
    end

    // Purpose: ready is high when suspended or when nothing runs or is pending.
    always_comb begin
        ready = (psusp_q || esusp_q) || ((state_i == ST_IDLE) && !eng_busy_i);
        status_o               = '0;
        status_o[SR_READY_BIT] = ready;
        status_o[SR_ESUSP_BIT] = esusp_q;
        status_o[SR_PSUSP_BIT] = psusp_q;
    end

endmodule

// File: rtl/susp_ctrl.sv
// Module: susp_ctrl (top)
// Program/erase suspend controller: gates commands, sequences the
// suspend/resume handshake with the write engine and reports status.
// Assumes: synchronous active-low reset; engine signals are synchronous to clk.
module susp_ctrl
    import susp_pkg::*;
#(
    parameter int                CODE_W      = 8,
    parameter logic [CODE_W-1:0] SUSP_CODE   = 8'hB0,
    parameter logic [CODE_W-1:0] RESUME_CODE = 8'hD0,
    parameter logic [CODE_W-1:0] RDSTAT_CODE = 8'h70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    input  logic [CODE_W-1:0] cmd_code_i,
    input  logic              eng_busy_i,
    input  logic              eng_erase_i,
    input  logic              eng_pause_ack_i,
    output logic              eng_pause_req_o,
    output logic              eng_resume_o,
    output logic              fwd_valid_o,
    output logic [CODE_W-1:0] fwd_code_o,
    output logic [7:0]        status_o
);

    susp_state_t state;
    logic        op_erase_q;
    logic        take_susp;
    logic        take_resume;
    logic        ev_enter;
    logic        ev_leave;

    susp_cmd_gate #(
        .CODE_W      (CODE_W),
        .SUSP_CODE   (SUSP_CODE),
        .RESUME_CODE (RESUME_CODE),
        .RDSTAT_CODE (RDSTAT_CODE)
    ) u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid_i  (cmd_valid_i),
        .cmd_code_i   (cmd_code_i),
        .state_i      (state),
        .op_erase_q_i (op_erase_q),
        .eng_busy_i   (eng_busy_i),
        .eng_erase_i  (eng_erase_i),
        .take_susp_o  (take_susp),
        .take_resume_o(take_resume),
        .fwd_valid_o  (fwd_valid_o),
        .fwd_code_o   (fwd_code_o)
    );

    susp_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .take_susp_i    (take_susp),
        .take_resume_i  (take_resume),
        .eng_busy_i     (eng_busy_i),
        .eng_erase_i    (eng_erase_i),
        .eng_pause_ack_i(eng_pause_ack_i),
        .state_o        (state),
        .op_erase_q_o   (op_erase_q),
        .ev_enter_o     (ev_enter),
        .ev_leave_o     (ev_leave),
        .pause_req_o    (eng_pause_req_o),
        .resume_o       (eng_resume_o)
    );

    susp_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_enter_i  (ev_enter),
        .ev_leave_i  (ev_leave),
        .op_erase_q_i(op_erase_q),
        .state_i     (state),
        .eng_busy_i  (eng_busy_i),
        .status_o    (status_o)
    );

endmodule

// File: rtl/susp_ctrl_chk.sv
// Module: susp_ctrl_chk
// Port-level assertions for susp_ctrl, attached with bind below.
module susp_ctrl_chk #(
    parameter int                CODE_W      = 8,
    parameter logic [CODE_W-1:0] SUSP_CODE   = 8'hB0,
    parameter logic [CODE_W-1:0] RESUME_CODE = 8'hD0,
    parameter logic [CODE_W-1:0] RDSTAT_CODE = 8'h70
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid_i,
    input logic [CODE_W-1:0] cmd_code_i,
    input logic              eng_busy_i,
    input logic              eng_erase_i,
    input logic              eng_pause_ack_i,
    input logic              eng_pause_req_o,
    input logic              eng_resume_o,
    input logic              fwd_valid_o,
    input logic [CODE_W-1:0] fwd_code_o,
    input logic [7:0]        status_o
);

    logic susp_any;
    assign susp_any = status_o[6] || status_o[2];

    // R2: a pending pause reports not ready
    a_r2_pending_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_pause_req_o && !susp_any) |-> !status_o[7]);

    // R3, R4: never both suspend flags; a suspend flag implies ready and pause held
    a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({status_o[6], status_o[2]}));

    a_r4_susp_implies_ready: assert property (@(posedge clk) disable iff (!rst_n)
        susp_any |-> (status_o[7] && eng_pause_req_o));

    // R5: suspended flags hold unless a resume code arrives
    a_r5_hold_suspended: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_any && !(cmd_valid_i && cmd_code_i == RESUME_CODE))
        |=> (status_o[6] == $past(status_o[6]) && status_o[2] == $past(status_o[2])));

    // R6: resume strobe lasts one cycle and comes with the pause released
    a_r6_resume_single: assert property (@(posedge clk) disable iff (!rst_n)
        eng_resume_o |=> !eng_resume_o);

    a_r6_resume_released: assert property (@(posedge clk) disable iff (!rst_n)
        eng_resume_o |-> (!eng_pause_req_o && !susp_any));

    // R7: erase running filters everything except read status
    a_r7_erase_filter: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && eng_busy_i && eng_erase_i && !eng_pause_req_o
         && cmd_code_i != RDSTAT_CODE) |=> !fwd_valid_o);

    // R8: suspend with the engine idle starts nothing
    a_r8_idle_suspend: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_code_i == SUSP_CODE && !eng_busy_i && !eng_pause_req_o)
        |=> (!eng_pause_req_o && !fwd_valid_o));

    // R10: suspend code is never forwarded
    a_r10_susp_not_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_code_i == SUSP_CODE) |=> !fwd_valid_o);

endmodule

bind susp_ctrl susp_ctrl_chk #(
    .CODE_W      (CODE_W),
    .SUSP_CODE   (SUSP_CODE),
    .RESUME_CODE (RESUME_CODE),
    .RDSTAT_CODE (RDSTAT_CODE)
) u_chk (.*);

// File: tb/tb_susp_ctrl.sv
module tb_susp_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] C_SUSP   = 8'hB0;
    localparam logic [7:0] C_RESUME = 8'hD0;
    localparam logic [7:0] C_RDSTAT = 8'h70;
    localparam logic [7:0] C_OTHER  = 8'h40;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_valid;
    logic [7:0] cmd_code;
    logic       busy, erase, ack;
    logic       pause_req, resume;
    logic       fwd_valid;
    logic [7:0] fwd_code;
    logic [7:0] status;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    susp_ctrl dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_valid_i    (cmd_valid),
        .cmd_code_i     (cmd_code),
        .eng_busy_i     (busy),
        .eng_erase_i    (erase),
        .eng_pause_ack_i(ack),
        .eng_pause_req_o(pause_req),
        .eng_resume_o   (resume),
        .fwd_valid_o    (fwd_valid),
        .fwd_code_o     (fwd_code),
        .status_o       (status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive a command for one cycle; returns at the next falling edge
    task automatic send(input logic [7:0] code);
        cmd_valid = 1'b1;
        cmd_code  = code;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_code  = 8'h00;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_code = 8'h00;
        busy = 1'b0; erase = 1'b0; ack = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 pause_req", pause_req, 0);
        chk("R1 resume", resume, 0);
        chk("R1 fwd_valid", fwd_valid, 0);
        chk("R1 status idle", status, 8'h80);
    endtask

    // suspend then resume one operation type; expected status bit by type
    task automatic t_suspend_resume(input logic is_erase);
        string rq;
        logic [7:0] exp_sr;
        rq = is_erase ? "R4" : "R3";
        exp_sr = is_erase ? 8'hC0 : 8'h84;
        do_reset();
        busy = 1'b1; erase = is_erase;
        @(negedge clk);
        chk("R2 busy not ready", status, 8'h00);
        send(C_SUSP);
        chk("R2 pause raised", pause_req, 1);
        chk("R2 ready low pending", status, 8'h00);
        chk("R10 suspend not forwarded", fwd_valid, 0);
        @(negedge clk);
        chk("R2 still pending", status, 8'h00);
        ack = 1'b1;
        @(negedge clk);
        chk({rq, " suspended status"}, status, exp_sr);
        chk({rq, " pause held"}, pause_req, 1);
        ack = 1'b0;
        @(negedge clk);
        chk("R5 hold after ack drop", status, exp_sr);
        send(C_RESUME);
        chk("R6 status cleared", status, 8'h00);
        chk("R6 pause dropped", pause_req, 0);
        chk("R6 resume pulse", resume, 1);
        chk("R6 resume not forwarded", fwd_valid, 0);
        @(negedge clk);
        chk("R6 resume one cycle", resume, 0);
    endtask

    task automatic t_erase_filter();
        do_reset();
        busy = 1'b1; erase = 1'b1;
        @(negedge clk);
        send(C_OTHER);
        chk("R7 other dropped", fwd_valid, 0);
        send(C_RESUME);
        chk("R7 0xD0 dropped in erase", fwd_valid, 0);
        send(C_RDSTAT);
        chk("R7 rdstat valid", fwd_valid, 1);
        chk("R7 rdstat code", fwd_code, C_RDSTAT);
    endtask

    task automatic t_idle_suspend();
        do_reset();
        send(C_SUSP);
        chk("R8 no pause", pause_req, 0);
        chk("R8 no fwd", fwd_valid, 0);
        chk("R8 status", status, 8'h80);
        busy = 1'b1;
        @(negedge clk);
        chk("R8 no late pause", pause_req, 0);
    endtask

    task automatic t_cancel();
        do_reset();
        busy = 1'b1; erase = 1'b0;
        @(negedge clk);
        send(C_SUSP);
        chk("R9 pending", pause_req, 1);
        busy = 1'b0;
        @(negedge clk);
        chk("R9 withdrawn", pause_req, 0);
        chk("R9 status ready only", status, 8'h80);
    endtask

    task automatic t_forward();
        do_reset();
        busy = 1'b1; erase = 1'b0;
        @(negedge clk);
        send(C_RESUME);
        chk("R10 0xD0 fwd in program", fwd_valid, 1);
        chk("R10 code", fwd_code, C_RESUME);
        send(C_SUSP);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        send(C_OTHER);
        chk("R10 fwd while suspended", fwd_valid, 1);
        chk("R10 fwd code suspended", fwd_code, C_OTHER);
        chk("R5 other cmd keeps suspend", status, 8'h84);
        busy = 1'b0;
        send(C_SUSP);
        chk("R5 busy/suspend change ignored", status, 8'h84);
        chk("R5 pause held", pause_req, 1);
        // R11: reset exits suspension
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R11 pause cleared", pause_req, 0);
        chk("R11 status", status, 8'h80);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_run++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=<20000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        rst_n = 1'b0;
        @(negedge clk);
        t_reset();
        t_suspend_resume(1'b0);
        t_suspend_resume(1'b1);
        t_erase_filter();
        t_idle_suspend();
        t_cancel();
        t_forward();
        finish_run();
    end

endmodule